// File: doc/BRIEF.md
# Host Control, Status and Interrupt Unit

This unit sits between a 36-bit host I/O bus and a packet network interface. A control write from the host sets the interface's configuration in one bus cycle: the interrupt priority level, the transmit and receive interrupt enables, the accept-any-destination switch, the byte-order mode, the flag that marks the next data word as the final address word, and the start and initialise commands. A status read returns one word that combines those settings with live conditions reported by the transmitter and receiver.

The unit also raises a priority interrupt. A request exists when a done flag and its enable are both set. It is sent out on one of seven request lines, chosen by decoding the 3-bit level. Level 0 keeps every line quiet. The transmit-done flag and the two error flags (CRC failure, transmit abort) are kept here. They are set by event pulses from the network side and cleared by commands. The other status fields pass straight through from their inputs.

Top module: `host_csr_unit`

## Requirements
- R1: After reset every held setting and flag is 0. With all status inputs at 0, the status word reads 0, no request line is active and neither command pulse is high.
- R2: A control write loads the level from bits 2..0, the transmit enable from bit 5, the receive enable from bit 8, accept-any from bit 9 and the mode from bit 11 (1 = 8-bit order). The new values appear in the status word and on the outputs from the clock edge that takes the write.
- R3: Transmit-done is set by a control write with bit 3 = 1 or by a `txDoneEvt` pulse. It is cleared by a start command. When a set and a clear arrive together, the set wins. A write with bit 3 = 0 and no start leaves it unchanged.
- R4: A control write with bit 6 = 1 produces `goPulse` high for exactly the one cycle after the write edge.
- R5: The last-word flag loads from bit 10 on every control write. A `dataWrEn` cycle with no control write clears it.
- R6: A control write with bit 12 = 1 produces a one-cycle `initPulse`. It clears both enables, transmit-done, last-word and both error flags, and these clears override set requests in the same write. It suppresses `goPulse`. The level, accept-any and mode still load.
- R7: The CRC-error and abort flags are set by `crcErrEvt` and `txAbortEvt`. They hold through control writes and are cleared only by initialise or reset.
- R8: Status layout: bits 2..0 level, 3 transmit-done, 4 `txBusy`, 5 transmit enable, 6 `rxDone`, 7 `rxActive`, 8 receive enable, 9 accept-any, 10 last-word, 11 mode, 12 `chanWait`, 13 CRC error, 14 abort, 17 `rxBitCnt[12]`, 21..18 `lostCount`, 35..24 `rxBitCnt[11:0]`. Bits 15, 16, 22 and 23 read 0.
- R9: The request is (`rxDone` AND receive enable) OR (transmit-done AND transmit enable). It follows `rxDone` in the same cycle.
- R10: With level k in 1..7, a request drives only `irqLines[k-1]`. Level 0 drives no line. At most one line is ever active.
- R11: Control-write bits 4, 7 and 35..13 have no effect on any setting, flag, pulse or line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control write strobe |
| ctlWrData | input | 36 | Control write word |
| dataWrEn | input | 1 | Data write strobe (clears last-word) |
| txBusy | input | 1 | Transmitter busy |
| rxDone | input | 1 | Receiver holds a complete message |
| rxActive | input | 1 | Receiver busy |
| chanWait | input | 1 | Transmitter waiting for the channel |
| txDoneEvt | input | 1 | Transmission finished pulse |
| crcErrEvt | input | 1 | CRC failure pulse |
| txAbortEvt | input | 1 | Transmission aborted pulse |
| lostCount | input | 4 | Lost-message count |
| rxBitCnt | input | 13 | Receive bit count; bit 12 is its sign |
| staRdData | output | 36 | Status word |
| irqLines | output | 7 | Priority request lines, bit k-1 for level k |
| matchAny | output | 1 | Accept any destination |
| lastWord | output | 1 | Next data write is the address word |
| byteMode | output | 1 | 1 = 8-bit order, 0 = 16-bit order |
| goPulse | output | 1 | Start-transmission pulse |
| initPulse | output | 1 | Initialise pulse |

## Verification
Every held setting, flag and command pulse changes at the clock edge that takes the write or event. The bench drives inputs on the falling edge and compares the status word, the level outputs and the pulses at the next falling edge, which is the first cycle in which the new value is due. It then checks again one cycle later to confirm that the pulses have dropped and the flags have held. The status bits that pass through and the request lines follow their inputs with no register in between. For these, the bench changes an input and compares one nanosecond later within the same low phase.

// File: rtl/host_csr_pkg.sv
`timescale 1ns/1ps
package host_csr_pkg;
  localparam int WORD_W = 36;
  localparam int PIA_W  = 3;
  localparam int LOST_W = 4;
  localparam int CNT_W  = 12;
  localparam int NUM_LINES = (1 << PIA_W) - 1;

  // control-write field positions
  localparam int CW_PIA    = 0;
  localparam int CW_SETDN  = 3;
  localparam int CW_TXEN   = 5;
  localparam int CW_GO     = 6;
  localparam int CW_RXEN   = 8;
  localparam int CW_MATCH  = 9;
  localparam int CW_LAST   = 10;
  localparam int CW_MODE   = 11;
  localparam int CW_INIT   = 12;

  // status-word field positions
  localparam int ST_PIA    = 0;
  localparam int ST_TXDN   = 3;
  localparam int ST_TXBSY  = 4;
  localparam int ST_TXEN   = 5;
  localparam int ST_RXDN   = 6;
  localparam int ST_RXACT  = 7;
  localparam int ST_RXEN   = 8;
  localparam int ST_MATCH  = 9;
  localparam int ST_LAST   = 10;
  localparam int ST_MODE   = 11;
  localparam int ST_CWAIT  = 12;
  localparam int ST_CRC    = 13;
  localparam int ST_ABORT  = 14;
  localparam int ST_SIGN   = 17;
  localparam int ST_LOST   = 18;
  localparam int ST_COUNT  = 24;

  typedef struct packed {
    logic             load;
    logic             init;
    logic             setTxDone;
    logic             clrTxDone;
    logic [PIA_W-1:0] piaVal;
    logic             txEnVal;
    logic             rxEnVal;
    logic             matchVal;
    logic             lastVal;
    logic             modeVal;
  } ctlStrb_t;
endpackage

// File: rtl/host_csr_ctl.sv
`timescale 1ns/1ps
module host_csr_ctl
  import host_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [WORD_W-1:0] ctlWrData,
  output ctlStrb_t          strb,
  output logic              goPulse,
  output logic              initPulse
);
  logic initReq;
  logic goReq;
  logic unusedBits;

  assign unusedBits = ^{ctlWrData[WORD_W-1:CW_INIT+1], ctlWrData[CW_RXEN-1], ctlWrData[CW_SETDN+1]};

  assign initReq = ctlWrEn && ctlWrData[CW_INIT];
  assign goReq   = ctlWrEn && ctlWrData[CW_GO] && !initReq;

  always_comb begin
    strb.load      = ctlWrEn;
    strb.init      = initReq;
    strb.setTxDone = ctlWrEn && ctlWrData[CW_SETDN] && !initReq;
    strb.clrTxDone = goReq;
    strb.piaVal    = ctlWrData[CW_PIA +: PIA_W];
    strb.txEnVal   = ctlWrData[CW_TXEN];
    strb.rxEnVal   = ctlWrData[CW_RXEN];
    strb.matchVal  = ctlWrData[CW_MATCH];
    strb.lastVal   = ctlWrData[CW_LAST];
    strb.modeVal   = ctlWrData[CW_MODE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goPulse   <= 1'b0;
      initPulse <= 1'b0;
    end else begin
      goPulse   <= goReq;
      initPulse <= initReq;
    end
  end

  // R4: a start write yields the pulse on the next cycle
  a_r4_go_follows: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CW_GO] && !ctlWrData[CW_INIT]) |=> goPulse);
  // R4: no pulse without a write on the previous edge
  a_r4_go_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    goPulse |-> $past(ctlWrEn));
  // R6: initialise pulses and suppresses start
  a_r6_init_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && ctlWrData[CW_INIT]) |=> (initPulse && !goPulse));
endmodule

// File: rtl/host_csr_regs.sv
`timescale 1ns/1ps
module host_csr_regs
  import host_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic              dataWrEn,
  input  logic              txDoneEvt,
  input  logic              crcErrEvt,
  input  logic              txAbortEvt,
  input  logic              txBusy,
  input  logic              rxDone,
  input  logic              rxActive,
  input  logic              chanWait,
  input  logic [LOST_W-1:0] lostCount,
  input  logic [CNT_W:0]    rxBitCnt,
  output logic [PIA_W-1:0]  pia,
  output logic              txIntEn,
  output logic              rxIntEn,
  output logic              txDone,
  output logic              matchAny,
  output logic              lastWord,
  output logic              byteMode,
  output logic [WORD_W-1:0] staRdData
);
  logic crcErr;
  logic txAbort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pia      <= '0;
      txIntEn  <= 1'b0;
      rxIntEn  <= 1'b0;
      txDone   <= 1'b0;
      matchAny <= 1'b0;
      lastWord <= 1'b0;
      byteMode <= 1'b0;
      crcErr   <= 1'b0;
      txAbort  <= 1'b0;
    end else begin
      if (strb.load) begin
        pia      <= strb.piaVal;
        matchAny <= strb.matchVal;
        byteMode <= strb.modeVal;
      end
      if (strb.init) begin
        txIntEn  <= 1'b0;
        rxIntEn  <= 1'b0;
        txDone   <= 1'b0;
        lastWord <= 1'b0;
        crcErr   <= 1'b0;
        txAbort  <= 1'b0;
      end else begin
        if (strb.load) begin
          txIntEn <= strb.txEnVal;
          rxIntEn <= strb.rxEnVal;
        end
        if (strb.setTxDone || txDoneEvt) txDone <= 1'b1;
        else if (strb.clrTxDone)         txDone <= 1'b0;
        if (strb.load)    lastWord <= strb.lastVal;
        else if (dataWrEn) lastWord <= 1'b0;
        if (crcErrEvt)  crcErr  <= 1'b1;
        if (txAbortEvt) txAbort <= 1'b1;
      end
    end
  end

  always_comb begin
    staRdData = '0;
    staRdData[ST_PIA +: PIA_W]    = pia;
    staRdData[ST_TXDN]            = txDone;
    staRdData[ST_TXBSY]           = txBusy;
    staRdData[ST_TXEN]            = txIntEn;
    staRdData[ST_RXDN]            = rxDone;
    staRdData[ST_RXACT]           = rxActive;
    staRdData[ST_RXEN]            = rxIntEn;
    staRdData[ST_MATCH]           = matchAny;
    staRdData[ST_LAST]            = lastWord;
    staRdData[ST_MODE]            = byteMode;
    staRdData[ST_CWAIT]           = chanWait;
    staRdData[ST_CRC]             = crcErr;
    staRdData[ST_ABORT]           = txAbort;
    staRdData[ST_SIGN]            = rxBitCnt[CNT_W];
    staRdData[ST_LOST +: LOST_W]  = lostCount;
    staRdData[ST_COUNT +: CNT_W]  = rxBitCnt[CNT_W-1:0];
  end

  // R6: initialise clears every held flag and enable
  a_r6_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.init |=> (!txIntEn && !rxIntEn && !txDone && !lastWord && !crcErr && !txAbort));
  // R7: error flag holds unless initialised
  a_r7_crc_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (crcErr && !strb.init) |=> crcErr);
  a_r7_abort_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txAbort && !strb.init) |=> txAbort);
  // R5: a lone data write clears last-word
  a_r5_data_clears_last: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && !strb.load) |=> !lastWord);
  // R3: done event sets the flag
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (txDoneEvt && !strb.init) |=> txDone);
endmodule

// File: rtl/host_csr_irq.sv
`timescale 1ns/1ps
module host_csr_irq
  import host_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIA_W-1:0]     pia,
  input  logic                 rxDone,
  input  logic                 rxIntEn,
  input  logic                 txDone,
  input  logic                 txIntEn,
  output logic [NUM_LINES-1:0] irqLines
);
  logic intReq;

  assign intReq = (rxDone && rxIntEn) || (txDone && txIntEn);

  for (genvar g = 1; g <= NUM_LINES; g++) begin : g_line
    assign irqLines[g-1] = intReq && (pia == PIA_W'(g));
  end

  // R10: never more than one line
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));
  // R10: level zero keeps all lines quiet
  a_r10_level_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pia == '0) |-> (irqLines == '0));
  // R9: no enable, no request
  a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (!rxIntEn && !txIntEn) |-> (irqLines == '0));
endmodule

// File: rtl/host_csr_unit.sv
`timescale 1ns/1ps
module host_csr_unit
  import host_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWrEn,
  input  logic [WORD_W-1:0]    ctlWrData,
  input  logic                 dataWrEn,
  input  logic                 txBusy,
  input  logic                 rxDone,
  input  logic                 rxActive,
  input  logic                 chanWait,
  input  logic                 txDoneEvt,
  input  logic                 crcErrEvt,
  input  logic                 txAbortEvt,
  input  logic [LOST_W-1:0]    lostCount,
  input  logic [CNT_W:0]       rxBitCnt,
  output logic [WORD_W-1:0]    staRdData,
  output logic [NUM_LINES-1:0] irqLines,
  output logic                 matchAny,
  output logic                 lastWord,
  output logic                 byteMode,
  output logic                 goPulse,
  output logic                 initPulse
);
  ctlStrb_t         strb;
  logic [PIA_W-1:0] pia;
  logic             txIntEn;
  logic             rxIntEn;
  logic             txDone;

  host_csr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .strb(strb), .goPulse(goPulse), .initPulse(initPulse)
  );

  host_csr_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .dataWrEn(dataWrEn),
    .txDoneEvt(txDoneEvt), .crcErrEvt(crcErrEvt), .txAbortEvt(txAbortEvt),
    .txBusy(txBusy), .rxDone(rxDone), .rxActive(rxActive), .chanWait(chanWait),
    .lostCount(lostCount), .rxBitCnt(rxBitCnt),
    .pia(pia), .txIntEn(txIntEn), .rxIntEn(rxIntEn), .txDone(txDone),
    .matchAny(matchAny), .lastWord(lastWord), .byteMode(byteMode),
    .staRdData(staRdData)
  );

  host_csr_irq u_irq (
    .clk(clk), .rstN(rstN), .pia(pia), .rxDone(rxDone), .rxIntEn(rxIntEn),
    .txDone(txDone), .txIntEn(txIntEn), .irqLines(irqLines)
  );
endmodule

// File: tb/host_csr_unit_tb.sv
`timescale 1ns/1ps
module host_csr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [35:0] ctlWrData = '0;
  logic        dataWrEn = 1'b0;
  logic        txBusy = 1'b0, rxDone = 1'b0, rxActive = 1'b0, chanWait = 1'b0;
  logic        txDoneEvt = 1'b0, crcErrEvt = 1'b0, txAbortEvt = 1'b0;
  logic [3:0]  lostCount = '0;
  logic [12:0] rxBitCnt = '0;
  logic [35:0] staRdData;
  logic [6:0]  irqLines;
  logic        matchAny, lastWord, byteMode, goPulse, initPulse;

  int checks = 0;
  int failures = 0;

  // bench model of held state
  logic [2:0] mPia = '0;
  logic mTxEn = 0, mRxEn = 0, mTxDone = 0, mMatch = 0, mLast = 0, mMode = 0, mCrc = 0, mAbort = 0;
  logic expGo = 0, expInit = 0;

  always #2.5 clk = ~clk;

  host_csr_unit u_dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .dataWrEn(dataWrEn), .txBusy(txBusy), .rxDone(rxDone), .rxActive(rxActive),
    .chanWait(chanWait), .txDoneEvt(txDoneEvt), .crcErrEvt(crcErrEvt),
    .txAbortEvt(txAbortEvt), .lostCount(lostCount), .rxBitCnt(rxBitCnt),
    .staRdData(staRdData), .irqLines(irqLines), .matchAny(matchAny),
    .lastWord(lastWord), .byteMode(byteMode), .goPulse(goPulse), .initPulse(initPulse)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] expStatus();
    logic [35:0] w = '0;
    w[2:0] = mPia; w[3] = mTxDone; w[4] = txBusy; w[5] = mTxEn;
    w[6] = rxDone; w[7] = rxActive; w[8] = mRxEn; w[9] = mMatch;
    w[10] = mLast; w[11] = mMode; w[12] = chanWait; w[13] = mCrc;
    w[14] = mAbort; w[17] = rxBitCnt[12]; w[21:18] = lostCount;
    w[35:24] = rxBitCnt[11:0];
    return w;
  endfunction

  function automatic logic [6:0] expIrq();
    logic req = (rxDone && mRxEn) || (mTxDone && mTxEn);
    if (req && mPia != 0) return 7'(1) << (mPia - 1);
    return '0;
  endfunction

  task automatic checkAll(input string req);
    chk({req, " status"}, staRdData, expStatus());
    chk({req, " outs"}, {33'd0, matchAny, lastWord, byteMode}, {33'd0, mMatch, mLast, mMode});
    chk({req, " irq"}, {29'd0, irqLines}, {29'd0, expIrq()});
  endtask

  task automatic ctlWrite(input logic [35:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
    mPia = d[2:0]; mMatch = d[9]; mMode = d[11];
    if (d[12]) begin
      mTxEn = 0; mRxEn = 0; mTxDone = 0; mLast = 0; mCrc = 0; mAbort = 0;
      expGo = 0; expInit = 1;
    end else begin
      mTxEn = d[5]; mRxEn = d[8]; mLast = d[10];
      if (d[3]) mTxDone = 1; else if (d[6]) mTxDone = 0;
      expGo = d[6]; expInit = 0;
    end
  endtask

  task automatic checkPulses(input string req);
    chk({req, " go"}, {35'd0, goPulse}, {35'd0, expGo});
    chk({req, " init"}, {35'd0, initPulse}, {35'd0, expInit});
    @(negedge clk);
    chk({req, " pulses drop"}, {34'd0, goPulse, initPulse}, 36'd0);
  endtask

  task automatic t_reset();
    chk("R1 status", staRdData, 36'd0);
    chk("R1 irq", {29'd0, irqLines}, 36'd0);
    chk("R1 pulses", {34'd0, goPulse, initPulse}, 36'd0);
    chk("R1 outs", {33'd0, matchAny, lastWord, byteMode}, 36'd0);
  endtask

  task automatic t_loads();
    ctlWrite(36'h0000_00B25);   // level 5, tx en, match, mode 8-bit
    checkAll("R2 load a");
    ctlWrite(36'h0000_00502);   // level 2, rx en, last-word
    checkAll("R2 load b");
    ctlWrite(36'h0);
    checkAll("R2 clear");
  endtask

  task automatic t_ignored();
    ctlWrite(36'h0000_00A23);
    checkAll("R11 base");
    ctlWrite(36'h0000_00A23 | 36'hFFFF_FE090);
    checkAll("R11 ignored bits");
    checkPulses("R11");
  endtask

  task automatic t_txdone();
    ctlWrite(36'h0000_00008);   // set done
    checkAll("R3 set by write");
    ctlWrite(36'h0000_00000);
    checkAll("R3 held on bit3=0");
    ctlWrite(36'h0000_00040);   // start
    checkAll("R3 cleared by start");
    checkPulses("R4 go pulse");
    @(negedge clk) txDoneEvt = 1'b1;
    @(negedge clk) txDoneEvt = 1'b0; mTxDone = 1;
    checkAll("R3 set by event");
    ctlWrite(36'h0000_00048);   // set and start together: set wins
    checkAll("R3 set beats start");
    checkPulses("R4 go with set");
  endtask

  task automatic t_last();
    ctlWrite(36'h0000_00400);
    checkAll("R5 loaded");
    @(negedge clk) dataWrEn = 1'b1;
    @(negedge clk) dataWrEn = 1'b0; mLast = 0;
    checkAll("R5 data write clears");
  endtask

  task automatic t_errors();
    @(negedge clk) begin crcErrEvt = 1'b1; txAbortEvt = 1'b1; end
    @(negedge clk) begin crcErrEvt = 1'b0; txAbortEvt = 1'b0; end
    mCrc = 1; mAbort = 1;
    checkAll("R7 flags set");
    ctlWrite(36'h0000_00123);
    checkAll("R7 held through write");
    ctlWrite(36'h0000_0176F);   // init with loads and set requests
    checkAll("R6 init clears, level/match/mode load");
    checkPulses("R6 init pulse, no go");
  endtask

  task automatic t_status();
    txBusy = 1; rxActive = 1; chanWait = 1; lostCount = 4'hA; rxBitCnt = 13'h1ABC;
    #1 checkAll("R8 layout a");
    txBusy = 0; rxActive = 0; chanWait = 0; lostCount = 4'h5; rxBitCnt = 13'h0543;
    #1 checkAll("R8 layout b");
    chk("R8 zero bits", staRdData & 36'h000C1_8000, 36'd0);
  endtask

  task automatic t_irq();
    for (int lvl = 0; lvl < 8; lvl++) begin
      ctlWrite(36'(lvl) | 36'h100);   // rx enable
      rxDone = 1'b1;
      #1 checkAll($sformatf("R10 level %0d", lvl));
      rxDone = 1'b0;
      #1 checkAll("R9 rxDone low");
    end
    ctlWrite(36'h0000_00008 | 36'h4); // done set, no tx enable, level 4
    checkAll("R9 done without enable");
    ctlWrite(36'h0000_00024);         // tx enable, done held
    checkAll("R9 tx term");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_loads();
    t_ignored();
    t_txdone();
    t_last();
    t_errors();
    t_status();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule